// File: doc/BRIEF.md
# Signed Fractional Multiplier with Requantization

This block multiplies two signed fraction-only operands. In each operand the top bit is the sign and every other bit is a fraction bit, so each operand covers the range from -1.0 up to just below +1.0. The block first forms the exact full-width product in one registered stage. In a second registered stage it brings that product back into the same fraction-only form at a width chosen by parameter. To do this it shifts the product, rounds away the low bits half-up, and removes the one integer bit that the product carries but almost never needs.

That integer bit is set only when both operands are -1.0. In that case the true result, +1.0, cannot be written in the output format. The block then clips the result to the largest positive code and raises a saturation flag for that sample. Every other operand pair yields an exact rounded result with the flag low.

A producer presents operands with a valid strobe, one sample per cycle at most. Results appear with their own valid strobe two cycles later. Between results, the result and the flag keep their last values.

Top module: `frac_mul_q`

## Requirements
- R1: While rstN is low, outValid, result and satFlag are all 0.
- R2: An operand pair sampled with inValid high at one rising edge produces outValid high in the cycle that follows the second rising edge after it. Exactly one result comes out per accepted pair, and pairs on consecutive cycles give results on consecutive cycles.
- R3: Operand encodings: opA is an A_W-bit two's complement code a with value a/2^(A_W-1). opB is a B_W-bit code b with value b/2^(B_W-1). The result is an OUT_W-bit code r with value r/2^(OUT_W-1). With S = A_W+B_W-1-OUT_W (OUT_W must not exceed A_W+B_W-1), r = floor(a*b/2^S + 1/2).
- R4: When the discarded low part is exactly half of one output LSB, the result rounds toward +infinity for both signs. Example with defaults (S=11): a=1024,b=1 gives 1; a=-1024,b=1 gives 0.
- R5: When opA is 100..0 and opB is 100..0 (both -1.0), the result is the largest positive code 2^(OUT_W-1)-1 (0x7FFF at defaults) and satFlag is 1 for that sample.
- R6: satFlag is 0 for every result that is representable after rounding. Whenever satFlag is 1, result is either the largest positive or the most negative code.
- R7: A product in which exactly one operand is -1.0 is never clipped. For example -1.0 times the largest positive opB gives the exact negated opB, scaled to the output.
- R8: While outValid is low, result and satFlag hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on opA/opB is valid this cycle |
| opA | input | A_W | First operand, signed, A_W-1 fraction bits |
| opB | input | B_W | Second operand, signed, B_W-1 fraction bits |
| outValid | output | 1 | result and satFlag carry a new sample |
| result | output | OUT_W | Requantized product, signed, OUT_W-1 fraction bits |
| satFlag | output | 1 | The sample on result was clipped |

## Verification
Two functions can act in the same cycle: the clip of the -1.0 by -1.0 case and the half-up rounding of the sample next to it. Because the stream runs back-to-back, the flag must also drop on the very next result. The bench provokes this by sending a saturating pair, a positive tie, a negative tie and a second saturating pair on consecutive cycles. A queue-based scoreboard judges every output cycle, comparing the code, the flag and the cycle of arrival against values computed from exact integer products. Random streams with gaps then check that the flag never rises elsewhere and that the outputs hold between results.

// File: rtl/frac_mul_q_pkg.sv
package frac_mul_q_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic captureProduct;  // load the full-precision product register
    logic captureResult;   // load the requantized result register
  } mulStrobes_t;

endpackage

// File: rtl/frac_mul_q_ctrl.sv
module frac_mul_q_ctrl
  import frac_mul_q_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output mulStrobes_t strobes,
  output logic        outValid
);

  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobes.captureProduct = inValid;
    strobes.captureResult  = stage1Valid;
  end

endmodule

// File: rtl/frac_mul_q_requant.sv
// Combinational shift, half-up rounding and clipping of a full-width
// fraction product back to an OUT_W-bit fraction-only code.
module frac_mul_q_requant #(
  parameter int PROD_W = 28,
  parameter int OUT_W  = 16
) (
  input  logic [PROD_W-1:0] product,
  output logic [OUT_W-1:0]  quantized,
  output logic              clipped
);

  localparam int SHIFT = PROD_W - 1 - OUT_W;
  localparam int EXT_W = PROD_W + 1;
  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic [EXT_W-1:0] extended;
  logic [EXT_W-1:0] biased;
  logic [2:0]       headBits;
  logic             fits;

  assign extended = {product[PROD_W-1], product};

  generate
    if (SHIFT > 0) begin : gRound
      logic unusedTail;
      assign biased     = extended + (EXT_W'(1) << (SHIFT - 1));
      assign unusedTail = ^biased[SHIFT-1:0];
    end else begin : gExact
      assign biased = extended;
    end
  endgenerate

  // Sign copy, redundant integer bit and output sign must agree.
  assign headBits = biased[PROD_W:PROD_W-2];
  assign fits     = (headBits == 3'b000) || (headBits == 3'b111);

  always_comb begin
    clipped = !fits;
    if (fits)
      quantized = biased[PROD_W-2:SHIFT];
    else if (biased[PROD_W])
      quantized = MIN_CODE;
    else
      quantized = MAX_CODE;
  end

endmodule

// File: rtl/frac_mul_q_datapath.sv
module frac_mul_q_datapath
  import frac_mul_q_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobes_t      strobes,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [OUT_W-1:0] result,
  output logic             satFlag
);

  localparam int PROD_W = A_W + B_W;

  logic signed [PROD_W-1:0] aWide;
  logic signed [PROD_W-1:0] bWide;
  logic [PROD_W-1:0]        productReg;
  logic [OUT_W-1:0]         rqValue;
  logic                     rqClip;

  assign aWide = {{B_W{opA[A_W-1]}}, opA};
  assign bWide = {{A_W{opB[B_W-1]}}, opB};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      productReg <= '0;
    else if (strobes.captureProduct)
      productReg <= aWide * bWide;
  end

  frac_mul_q_requant #(
    .PROD_W(PROD_W),
    .OUT_W (OUT_W)
  ) uRequant (
    .product  (productReg),
    .quantized(rqValue),
    .clipped  (rqClip)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      satFlag <= 1'b0;
    end else if (strobes.captureResult) begin
      result  <= rqValue;
      satFlag <= rqClip;
    end
  end

endmodule

// File: rtl/frac_mul_q.sv
module frac_mul_q
  import frac_mul_q_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic             outValid,
  output logic [OUT_W-1:0] result,
  output logic             satFlag
);

  mulStrobes_t strobes;

  frac_mul_q_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  frac_mul_q_datapath #(
    .A_W  (A_W),
    .B_W  (B_W),
    .OUT_W(OUT_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .satFlag(satFlag)
  );

endmodule

// File: rtl/frac_mul_q_checker.sv
module frac_mul_q_checker #(
  parameter int A_W   = 16,
  parameter int B_W   = 12,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [A_W-1:0]   opA,
  input logic [B_W-1:0]   opB,
  input logic             outValid,
  input logic [OUT_W-1:0] result,
  input logic             satFlag
);

  localparam logic [A_W-1:0]   MIN_A   = {1'b1, {(A_W-1){1'b0}}};
  localparam logic [B_W-1:0]   MIN_B   = {1'b1, {(B_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_OUT = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sinceReset <= '0;
    else if (sinceReset != 2'd3)
      sinceReset <= sinceReset + 2'd1;
  end

  // R1: outputs cleared while reset is held
  always_comb begin
    if (rstN === 1'b0)
      assert_reset_clear_R1: assert (outValid == 1'b0 && result == '0 && satFlag == 1'b0);
  end

  // R2: valid emerges two edges after acceptance
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R5: -1.0 times -1.0 gives the largest positive code with the flag
  assert_min_squared_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && $past(inValid && opA == MIN_A && opB == MIN_B, 2))
      |-> (satFlag && result == MAX_OUT));

  // R6: a clipped sample always sits on a range end
  assert_clip_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && satFlag) |-> (result == MAX_OUT || result == MIN_OUT));

  // R8: outputs hold between results
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd1 && !outValid) |-> ($stable(result) && $stable(satFlag)));

endmodule

bind frac_mul_q frac_mul_q_checker #(
  .A_W  (A_W),
  .B_W  (B_W),
  .OUT_W(OUT_W)
) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opA     (opA),
  .opB     (opB),
  .outValid(outValid),
  .result  (result),
  .satFlag (satFlag)
);

// File: tb/tb_frac_mul_q.sv
`timescale 1ns/1ps
module tb_frac_mul_q;

  localparam int A_W   = 16;
  localparam int B_W   = 12;
  localparam int OUT_W = 16;
  localparam int SH    = A_W + B_W - 1 - OUT_W;
  localparam longint MAXV = (longint'(1) << (OUT_W - 1)) - 1;
  localparam longint MINV = -(longint'(1) << (OUT_W - 1));

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [A_W-1:0]   opA = '0;
  logic [B_W-1:0]   opB = '0;
  logic             outValid;
  logic [OUT_W-1:0] result;
  logic             satFlag;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  typedef struct {
    logic [OUT_W-1:0] res;
    logic             sat;
    int               due;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];

  frac_mul_q #(.A_W(A_W), .B_W(B_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .satFlag(satFlag)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference: exact integer product, half-up rounding, clip to range.
  task automatic drive(input longint a, input longint b, input string tag);
    longint p, r;
    bit s;
    @(negedge clk);
    opA = A_W'(a);
    opB = B_W'(b);
    inValid = 1'b1;
    p = a * b;
    r = (SH > 0) ? ((p + (longint'(1) << (SH - 1))) >>> SH) : p;
    s = 1'b0;
    if (r > MAXV) begin r = MAXV; s = 1'b1; end
    if (r < MINV) begin r = MINV; s = 1'b1; end
    expQ.push_back('{res: OUT_W'(r), sat: s, due: cycleCount + 2, tag: tag});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    opA = A_W'($urandom);
    opB = B_W'($urandom);
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor / scoreboard
  logic [OUT_W-1:0] lastRes = '0;
  logic             lastSat = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2 unexpected result", 1, 0);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(result == e.res, {e.tag, " result"},
                  longint'($signed(result)), longint'($signed(e.res)));
            check(satFlag == e.sat, {e.tag, " satFlag (R6)"}, satFlag, e.sat);
            check(cycleCount == e.due, "R2 arrival cycle", cycleCount, e.due);
          end
          lastRes = result;
          lastSat = satFlag;
        end else begin
          check(result == lastRes && satFlag == lastSat, "R8 hold",
                longint'($signed(result)), longint'($signed(lastRes)));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    check(result == '0, "R1 result in reset", longint'(result), 0);
    check(satFlag == 1'b0, "R1 satFlag in reset", satFlag, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R3: directed products
    drive(16384, 1024, "R3 half times half");
    drive(32767, -2048, "R3 max times -1");
    drive(0, 2047, "R3 zero");
    drive(-12345, 777, "R3 mixed sign");
    idle(4);

    // R7: exactly one operand -1.0
    drive(-32768, 2047, "R7 -1 times max");
    drive(-32768, 1024, "R7 -1 times half");
    drive(16384, -2048, "R7 half times -1");
    idle(4);

    // R5 and R4 back-to-back: clip next to ties, flag must drop
    drive(-32768, -2048, "R5 -1 times -1");
    drive(1024, 1, "R4 positive tie");
    drive(-1024, 1, "R4 negative tie");
    drive(-32768, -2048, "R5 -1 times -1 again");
    drive(-3072, 1, "R4 negative tie 1.5");
    idle(5);

    // R3/R6: random streams with gaps
    for (int i = 0; i < 400; i++) begin
      drive(longint'($signed(A_W'($urandom))), longint'($signed(B_W'($urandom))), "R3 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    check(expQ.size() == 0, "R2 all results delivered", expQ.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule